// File: doc/BRIEF.md
# Synchronous-to-Asynchronous Receive Rate Adapter

This block sits on the receive side of a link whose line carries start-stop characters as a plain synchronous bit stream. One bit arrives per receive-clock strobe. The block frames that stream into characters and rebuilds a start-stop waveform on a 16x tick. If the far end squeezed out a stop bit to absorb an overspeed, the block puts that stop bit back. It then shortens the stop bits that follow until the lost time is recovered, so a one-character elastic buffer never fills. A run of space bits longer than any character is taken as a break and is passed to the output instead of being chopped into characters.

Two simpler paths replace the converter when asked. In high-speed-timing mode the synchronous bit is copied straight to the output on each receive strobe. In bypass mode the output is wired to the input. Parity checking and clock recovery are left to the surrounding logic.

Top module: `rx_rate_adapter`

## Requirements
- R1: `rx_data` is captured only on clocks where `bit_stb` is high; 1 is mark and 0 is space. A character is M = 8 + `len_sel` bits long (`len_sel` 0..3 gives 8..11). It consists of one space start bit, M-2 data bits sent least significant first, and one mark stop bit.
- R2: After reset `async_out` idles at mark. Framing starts at the first space bit received; leading mark bits are ignored.
- R3: With no stop-bit deficit, every character is reproduced with its start bit, each data bit and its stop bit lasting 16 ticks each. Characters that arrive back to back leave back to back.
- R4: With `tick_stb` high on every clock and the output idle, the falling edge of a character's start bit appears on `async_out` two clocks after the clock whose strobe carried that character's stop position.
- R5: A space at the stop position marks a missing stop bit. The character is still delivered with a mark stop bit, and that space bit is taken as the start bit of the next character.
- R6: Each reinserted stop bit adds 16 ticks of deficit. While the deficit is non-zero, every output stop bit lasts 14 ticks when `ext_rate`=0, reducing the deficit by 2, and 12 ticks when `ext_rate`=1, reducing it by 4. Once the deficit reaches zero, stop bits return to 16 ticks.
- R7: After 2M+3 consecutive space bits the output is held at space from two clocks after the strobe of the last of them. Buffered characters are discarded and no stop bit is inserted. The first mark bit ends the break: the output goes to mark two clocks later and framing restarts at the next space bit.
- R8: With `hs_mode`=1 and `sync_bypass`=0, `async_out` equals the `rx_data` value captured at the latest strobe, one clock after that strobe.
- R9: With `sync_bypass`=1, `async_out` equals `rx_data` in the same cycle, whatever `hs_mode` is.
- R10: No character is lost. The elastic buffer of FIFO_DEPTH characters never overflows for input that deletes at most one stop bit per deficit-recovery period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_stb | input | 1 | One-clock strobe marking a rising receive-clock edge |
| rx_data | input | 1 | Synchronous receive data bit |
| tick_stb | input | 1 | Output timing strobe, 16 per bit |
| len_sel | input | SEL_W | Character length select, M = BASE_LEN + len_sel |
| ext_rate | input | 1 | 1 selects the extended-rate stop shortening |
| hs_mode | input | 1 | 1 routes the captured synchronous bit straight to the output |
| sync_bypass | input | 1 | 1 connects rx_data directly to the output |
| async_out | output | 1 | Regenerated start-stop data |

## Verification
In converter mode the first start edge is due two clocks after the strobe that carried the stop position. Every later bit boundary falls a whole number of ticks after that edge, so the bench records `async_out` on every falling clock edge and reads data bits at the middle of each 16-tick cell counted from the detected start edge. It measures stop lengths as the distance to the next start edge. High-speed-timing results are checked one clock after each strobe, and bypass results a fraction of a cycle after the input changes. The break output is checked over the whole window from two clocks after the (2M+3)th space strobe to the first mark strobe, and the return to mark exactly two clocks after that strobe.

// File: rtl/rxa_pkg.sv
package rxa_pkg;

   typedef enum logic [1:0] {
      SER_IDLE,
      SER_START,
      SER_DATA,
      SER_STOP
   } ser_state_e;

endpackage

// File: rtl/rxa_frame_parser.sv
// Frames the synchronous bit stream into characters, flags missing stop
// bits and recognises breaks (long runs of space).
module rxa_frame_parser #(
   parameter int DATA_W = 9,
   parameter int LEN_W  = 4,
   parameter int RUN_W  = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bit_stb,
   input  logic              rx_bit,
   input  logic [LEN_W-1:0]  m_len,
   output logic              push,
   output logic [DATA_W-1:0] push_data,
   output logic              push_miss,
   output logic              brk
);

   localparam int DI_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
   localparam logic [RUN_W-1:0] RUN_MAX = '1;

   logic [LEN_W-1:0]  idx_q;
   logic [RUN_W-1:0]  zrun_q;
   logic [RUN_W-1:0]  zrun_nxt;
   logic [RUN_W-1:0]  brk_thr;
   logic [DATA_W-1:0] data_q;
   logic              brk_q;
   logic              hit_brk;
   logic              at_stop;

   // break threshold 2M+3
   assign brk_thr  = (RUN_W'(m_len) << 1) + RUN_W'(3);
   assign zrun_nxt = rx_bit ? '0 :
                     ((zrun_q == RUN_MAX) ? zrun_q : zrun_q + 1'b1);
   assign hit_brk  = !brk_q && (zrun_nxt >= brk_thr);
   assign at_stop  = (idx_q != '0) && (idx_q == m_len - 1'b1);

   assign push      = bit_stb && !brk_q && !hit_brk && at_stop;
   assign push_data = data_q;
   assign push_miss = !rx_bit;
   assign brk       = brk_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         idx_q  <= '0;
         zrun_q <= '0;
         data_q <= '0;
         brk_q  <= 1'b0;
      end else if (bit_stb) begin
         zrun_q <= zrun_nxt;
         if (brk_q) begin
            if (rx_bit) begin
               brk_q <= 1'b0;
               idx_q <= '0;
            end
         end else if (hit_brk) begin
            brk_q <= 1'b1;
            idx_q <= '0;
         end else if (idx_q == '0) begin
            if (!rx_bit) idx_q <= LEN_W'(1);
         end else if (at_stop) begin
            // a space here is the next start bit
            idx_q <= rx_bit ? '0 : LEN_W'(1);
         end else begin
            data_q[DI_W'(idx_q - 1'b1)] <= rx_bit;
            idx_q <= idx_q + 1'b1;
         end
      end
   end

endmodule

// File: rtl/rxa_char_fifo.sv
// Show-ahead character buffer; DEPTH of one uses a single holding register.
module rxa_char_fifo #(
   parameter int WIDTH = 10,
   parameter int DEPTH = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush,
   input  logic             wr_en,
   input  logic [WIDTH-1:0] wr_data,
   input  logic             rd_en,
   output logic [WIDTH-1:0] rd_data,
   output logic             empty,
   output logic             full
);

   generate
      if (DEPTH == 1) begin : g_single
         logic [WIDTH-1:0] hold_q;
         logic             valid_q;

         assign rd_data = hold_q;
         assign empty   = !valid_q;
         assign full    = valid_q;

         always_ff @(posedge clk) begin
            if (!rst_n || flush) begin
               valid_q <= 1'b0;
               hold_q  <= '0;
            end else begin
               if (rd_en) valid_q <= 1'b0;
               if (wr_en && (!valid_q || rd_en)) begin
                  hold_q  <= wr_data;
                  valid_q <= 1'b1;
               end
            end
         end
      end else begin : g_ring
         localparam int PTR_W = $clog2(DEPTH);
         localparam int CNT_W = $clog2(DEPTH + 1);
         localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
         localparam logic [CNT_W-1:0] CAP  = CNT_W'(DEPTH);

         logic [WIDTH-1:0] mem_q [DEPTH];
         logic [PTR_W-1:0] wptr_q;
         logic [PTR_W-1:0] rptr_q;
         logic [CNT_W-1:0] cnt_q;
         logic             wr_ok;
         logic             rd_ok;

         assign empty   = (cnt_q == '0);
         assign full    = (cnt_q == CAP);
         assign rd_data = mem_q[rptr_q];
         assign rd_ok   = rd_en && !empty;
         assign wr_ok   = wr_en && (!full || rd_ok);

         always_ff @(posedge clk) begin
            if (!rst_n || flush) begin
               wptr_q <= '0;
               rptr_q <= '0;
               cnt_q  <= '0;
            end else begin
               if (wr_ok) begin
                  wptr_q <= (wptr_q == LAST) ? '0 : wptr_q + 1'b1;
               end
               if (rd_ok) begin
                  rptr_q <= (rptr_q == LAST) ? '0 : rptr_q + 1'b1;
               end
               if (wr_ok && !rd_ok)      cnt_q <= cnt_q + 1'b1;
               else if (rd_ok && !wr_ok) cnt_q <= cnt_q - 1'b1;
            end
         end

         always_ff @(posedge clk) begin
            if (wr_ok) mem_q[wptr_q] <= wr_data;
         end
      end
   endgenerate

   // R10: a character offered to a full buffer would be lost
   p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n || flush)
      !(wr_en && full && !rd_en));

   // R10: the reader never takes from an empty buffer
   p_no_underflow_r10: assert property (@(posedge clk) disable iff (!rst_n || flush)
      rd_en |-> !empty);

endmodule

// File: rtl/rxa_async_serializer.sv
// Regenerates start-stop characters on the tick strobe and shortens stop
// bits while a reinsertion deficit is outstanding.
module rxa_async_serializer
   import rxa_pkg::*;
#(
   parameter int TICKS       = 16,
   parameter int SHORT_BASIC = 2,
   parameter int SHORT_EXT   = 4,
   parameter int DATA_W      = 9,
   parameter int LEN_W       = 4,
   parameter int DEBT_W      = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              brk,
   input  logic              ext_rate,
   input  logic [LEN_W-1:0]  m_len,
   input  logic              fifo_empty,
   input  logic [DATA_W-1:0] fifo_data,
   input  logic              fifo_miss,
   output logic              pop,
   output logic              ser_out
);

   localparam int TC_W = $clog2(TICKS + 1);
   localparam logic [TC_W-1:0]   FULL_LEN = TC_W'(TICKS);
   localparam logic [DEBT_W-1:0] DEBT_MAX = '1;
   localparam logic [DEBT_W-1:0] DEBT_ADD = DEBT_W'(TICKS);

   ser_state_e        state_q;
   logic [TC_W-1:0]   tcnt_q;
   logic [TC_W-1:0]   stop_len_q;
   logic [TC_W-1:0]   short_len;
   logic [LEN_W-1:0]  bidx_q;
   logic [DATA_W-1:0] sh_q;
   logic              out_q;
   logic [DEBT_W-1:0] debt_q;
   logic [DEBT_W-1:0] debt_nxt;
   logic [DEBT_W-1:0] shave;
   logic              bit_done;
   logic              stop_done;

   assign shave     = ext_rate ? DEBT_W'(SHORT_EXT) : DEBT_W'(SHORT_BASIC);
   assign short_len = ext_rate ? TC_W'(TICKS - SHORT_EXT) : TC_W'(TICKS - SHORT_BASIC);
   assign bit_done  = (tcnt_q == FULL_LEN - 1'b1);
   assign stop_done = (state_q == SER_STOP) && (tcnt_q == stop_len_q - 1'b1);
   assign pop       = tick && !brk && !fifo_empty &&
                      ((state_q == SER_IDLE) || stop_done);
   assign ser_out   = out_q;

   always_comb begin
      debt_nxt = debt_q;
      if (tick && stop_done) begin
         debt_nxt = (debt_nxt > shave) ? debt_nxt - shave : '0;
      end
      if (pop && fifo_miss) begin
         debt_nxt = (debt_nxt > DEBT_MAX - DEBT_ADD) ? DEBT_MAX : debt_nxt + DEBT_ADD;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q    <= SER_IDLE;
         tcnt_q     <= '0;
         stop_len_q <= FULL_LEN;
         bidx_q     <= '0;
         sh_q       <= '0;
         out_q      <= 1'b1;
         debt_q     <= '0;
      end else if (brk) begin
         state_q <= SER_IDLE;
         tcnt_q  <= '0;
         out_q   <= 1'b0;
         debt_q  <= '0;
      end else if (tick) begin
         debt_q <= debt_nxt;
         case (state_q)
            SER_IDLE: begin
               out_q <= 1'b1;
               if (pop) begin
                  state_q <= SER_START;
                  out_q   <= 1'b0;
                  tcnt_q  <= '0;
                  sh_q    <= fifo_data;
               end
            end
            SER_START: begin
               if (bit_done) begin
                  state_q <= SER_DATA;
                  out_q   <= sh_q[0];
                  tcnt_q  <= '0;
                  bidx_q  <= '0;
               end else begin
                  tcnt_q <= tcnt_q + 1'b1;
               end
            end
            SER_DATA: begin
               if (bit_done) begin
                  tcnt_q <= '0;
                  if (bidx_q == m_len - LEN_W'(3)) begin
                     state_q    <= SER_STOP;
                     out_q      <= 1'b1;
                     stop_len_q <= (debt_q != '0) ? short_len : FULL_LEN;
                  end else begin
                     bidx_q <= bidx_q + 1'b1;
                     out_q  <= sh_q[1];
                     sh_q   <= sh_q >> 1;
                  end
               end else begin
                  tcnt_q <= tcnt_q + 1'b1;
               end
            end
            SER_STOP: begin
               if (stop_done) begin
                  tcnt_q <= '0;
                  if (pop) begin
                     state_q <= SER_START;
                     out_q   <= 1'b0;
                     sh_q    <= fifo_data;
                  end else begin
                     state_q <= SER_IDLE;
                  end
               end else begin
                  tcnt_q <= tcnt_q + 1'b1;
               end
            end
            default: state_q <= SER_IDLE;
         endcase
      end
   end

   // R6: a finished stop bit with a deficit outstanding always lowers it
   p_debt_shrink_r6: assert property (@(posedge clk) disable iff (!rst_n || brk)
      (tick && stop_done && (debt_q != '0) && !(pop && fifo_miss))
      |=> (debt_q < $past(debt_q)));

   // R5: the stop cell sent after a character is always mark
   p_stop_is_mark_r5: assert property (@(posedge clk) disable iff (!rst_n || brk)
      ($past(state_q) == SER_STOP) && (state_q == SER_STOP) |-> out_q);

endmodule

// File: rtl/rx_rate_adapter.sv
module rx_rate_adapter #(
   parameter int BASE_LEN      = 8,
   parameter int SEL_W         = 2,
   parameter int TICKS_PER_BIT = 16,
   parameter int SHORT_BASIC   = 2,
   parameter int SHORT_EXT     = 4,
   parameter int FIFO_DEPTH    = 2,
   parameter int DEBT_W        = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bit_stb,
   input  logic             rx_data,
   input  logic             tick_stb,
   input  logic [SEL_W-1:0] len_sel,
   input  logic             ext_rate,
   input  logic             hs_mode,
   input  logic             sync_bypass,
   output logic             async_out
);

   localparam int MAX_LEN = BASE_LEN + (1 << SEL_W) - 1;
   localparam int DATA_W  = MAX_LEN - 2;
   localparam int LEN_W   = $clog2(MAX_LEN + 1);
   localparam int RUN_W   = $clog2(2 * MAX_LEN + 4);

   generate
      if (BASE_LEN < 4) begin : g_chk_len
         $error("BASE_LEN must leave at least two data bits");
      end
      if (SHORT_BASIC >= TICKS_PER_BIT || SHORT_EXT >= TICKS_PER_BIT) begin : g_chk_short
         $error("stop shortening must be smaller than one bit");
      end
      if (TICKS_PER_BIT >= (1 << DEBT_W)) begin : g_chk_debt
         $error("DEBT_W too narrow for one inserted bit");
      end
      if (FIFO_DEPTH < 1) begin : g_chk_depth
         $error("FIFO_DEPTH must be at least one");
      end
   endgenerate

   logic [LEN_W-1:0]  m_len;
   logic              push;
   logic [DATA_W-1:0] push_data;
   logic              push_miss;
   logic              brk;
   logic [DATA_W:0]   rd_word;
   logic              fifo_empty;
   logic              fifo_full;
   logic              pop;
   logic              ser_out;
   logic              hs_q;

   assign m_len = LEN_W'(BASE_LEN) + LEN_W'(len_sel);

   rxa_frame_parser #(
      .DATA_W (DATA_W),
      .LEN_W  (LEN_W),
      .RUN_W  (RUN_W)
   ) u_parser (
      .clk       (clk),
      .rst_n     (rst_n),
      .bit_stb   (bit_stb),
      .rx_bit    (rx_data),
      .m_len     (m_len),
      .push      (push),
      .push_data (push_data),
      .push_miss (push_miss),
      .brk       (brk)
   );

   rxa_char_fifo #(
      .WIDTH (DATA_W + 1),
      .DEPTH (FIFO_DEPTH)
   ) u_fifo (
      .clk     (clk),
      .rst_n   (rst_n),
      .flush   (brk),
      .wr_en   (push),
      .wr_data ({push_miss, push_data}),
      .rd_en   (pop),
      .rd_data (rd_word),
      .empty   (fifo_empty),
      .full    (fifo_full)
   );

   rxa_async_serializer #(
      .TICKS       (TICKS_PER_BIT),
      .SHORT_BASIC (SHORT_BASIC),
      .SHORT_EXT   (SHORT_EXT),
      .DATA_W      (DATA_W),
      .LEN_W       (LEN_W),
      .DEBT_W      (DEBT_W)
   ) u_ser (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick       (tick_stb),
      .brk        (brk),
      .ext_rate   (ext_rate),
      .m_len      (m_len),
      .fifo_empty (fifo_empty),
      .fifo_data  (rd_word[DATA_W-1:0]),
      .fifo_miss  (rd_word[DATA_W]),
      .pop        (pop),
      .ser_out    (ser_out)
   );

   // high-speed-timing path: one register on the receive strobe
   always_ff @(posedge clk) begin
      if (!rst_n)       hs_q <= 1'b1;
      else if (bit_stb) hs_q <= rx_data;
   end

   assign async_out = sync_bypass ? rx_data : (hs_mode ? hs_q : ser_out);

   // R8: high-speed path shows the bit captured at the previous strobe
   p_hs_follow_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(bit_stb) && hs_mode && !sync_bypass)
      |-> (async_out == $past(rx_data)));

   // R7: once a break is established the converter output stays at space
   p_break_space_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(brk) && brk && !hs_mode && !sync_bypass)
      |-> !async_out);

   // R10: buffer state seen at the top agrees with the parser's offers
   p_full_no_push_r10: assert property (@(posedge clk) disable iff (!rst_n || brk)
      (fifo_full && !pop) |-> !push);

endmodule

// File: tb/rx_rate_adapter_tb_top.sv
module rx_rate_adapter_tb_top;

   localparam int LOGN = 8192;
   localparam int TPB  = 16;

   logic       clk = 1'b0;
   logic       rst_n;
   logic       bit_stb;
   logic       rx_data;
   logic       tick_stb;
   logic [1:0] len_sel;
   logic       ext_rate;
   logic       hs_mode;
   logic       sync_bypass;
   logic       async_out;

   int total = 0;
   int bad   = 0;
   int lp    = 0;
   int nb    = 0;
   logic lg  [LOGN];
   logic txb [4096];
   int exp_d  [32];
   int exp_st [32];
   bit drop_f [32];

   always #10 clk = ~clk;

   rx_rate_adapter dut_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .bit_stb     (bit_stb),
      .rx_data     (rx_data),
      .tick_stb    (tick_stb),
      .len_sel     (len_sel),
      .ext_rate    (ext_rate),
      .hs_mode     (hs_mode),
      .sync_bypass (sync_bypass),
      .async_out   (async_out)
   );

   task automatic chk(input bit ok, input string req, input int act, input int expv);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s act=%0d exp=%0d", req, act, expv);
      end
   endtask

   // sample output first, then drive: one process, fixed order
   task automatic step(input logic stb, input logic d);
      @(negedge clk);
      if (lp < LOGN) lg[lp] = async_out;
      lp++;
      bit_stb = stb;
      rx_data = d;
   endtask

   task automatic do_reset();
      rst_n = 1'b0; bit_stb = 1'b0; rx_data = 1'b1; tick_stb = 1'b1;
      repeat (4) step(1'b0, 1'b1);
      rst_n = 1'b1;
      repeat (2) step(1'b0, 1'b1);
      nb = 0;
   endtask

   task automatic add_bit(input logic b);
      txb[nb] = b;
      nb++;
   endtask

   task automatic add_char(input int m, input int d, input bit drop);
      add_bit(1'b0);
      for (int j = 0; j < m - 2; j++) add_bit(d[j]);
      if (!drop) add_bit(1'b1);
   endtask

   task automatic play();
      lp = 0;
      for (int b = 0; b < nb; b++) begin
         step(1'b1, txb[b]);
         repeat (TPB - 1) step(1'b0, txb[b]);
      end
      bit_stb = 1'b0;
   endtask

   function automatic int find_fall(input int from);
      for (int k = (from < 1 ? 1 : from); k < lp && k < LOGN; k++) begin
         if (lg[k-1] == 1'b1 && lg[k] == 1'b0) return k;
      end
      return -1;
   endfunction

   // expected stop lengths from the deficit rule (R6)
   task automatic plan_stops(input int n, input bit ext);
      int debt;
      int s;
      debt = 0;
      s = ext ? 4 : 2;
      for (int i = 0; i < n; i++) begin
         if (drop_f[i]) debt += TPB;
         exp_st[i] = (debt > 0) ? TPB - s : TPB;
         debt = (debt > s) ? debt - s : 0;
      end
      exp_st[n-1] = -1;
   endtask

   task automatic check_stream(input int m, input int n, input int from,
                               input int first_fall, input string dtag, input string stag);
      int s;
      int p;
      int f;
      int d;
      s = find_fall(from);
      if (first_fall >= 0) chk(s == first_fall, "R4 first start edge", s, first_fall);
      for (int i = 0; i < n; i++) begin
         if (s < 0) begin
            chk(1'b0, {dtag, " character missing"}, i, n);
            break;
         end
         d = 0;
         for (int j = 0; j < m - 2; j++) d[j] = lg[s + TPB * (1 + j) + TPB / 2];
         chk(d == exp_d[i], {dtag, " data"}, d, exp_d[i]);
         p = s + TPB * (m - 1);
         f = find_fall(p + 1);
         if (exp_st[i] > 0) chk((f - p) == exp_st[i], {stag, " stop length"}, f - p, exp_st[i]);
         s = f;
      end
   endtask

   initial begin
      #(20 * 190000);
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      int ones;
      int m;
      int d;
      void'($urandom(32'd20240611));
      len_sel = 2'd0; ext_rate = 1'b0; hs_mode = 1'b0; sync_bypass = 1'b0;

      // R2: idle mark after reset
      do_reset();
      #2;
      chk(async_out == 1'b1, "R2 reset idle", async_out, 1);

      // R1 R2 R3 R4: normal characters for each length, leading marks
      for (int sel = 0; sel < 4; sel++) begin
         len_sel = sel[1:0];
         ext_rate = 1'($urandom % 2);
         do_reset();
         m = 8 + sel;
         repeat (3) add_bit(1'b1);
         for (int i = 0; i < 5; i++) begin
            exp_d[i] = int'($urandom) & ((1 << (m - 2)) - 1);
            exp_st[i] = (i == 4) ? -1 : TPB;
            add_char(m, exp_d[i], 1'b0);
         end
         repeat (3 * m) add_bit(1'b1);
         play();
         check_stream(m, 5, 1, TPB * (3 + m - 1) + 2, "R1", "R3");
      end

      // R5 R6 R10: missing stop, basic rate, M=8
      len_sel = 2'd0; ext_rate = 1'b0;
      do_reset();
      for (int i = 0; i < 11; i++) begin
         exp_d[i] = int'($urandom) & 8'h3F;
         drop_f[i] = (i == 1);
         add_char(8, exp_d[i], drop_f[i]);
      end
      plan_stops(11, 1'b0);
      repeat (24) add_bit(1'b1);
      play();
      check_stream(8, 11, 1, -1, "R10", "R6");
      chk(exp_st[1] == 14, "R5 inserted stop planned", exp_st[1], 14);

      // R5 R6: missing stop, extended rate, M=11
      len_sel = 2'd3; ext_rate = 1'b1;
      do_reset();
      for (int i = 0; i < 7; i++) begin
         exp_d[i] = int'($urandom) & 12'h1FF;
         drop_f[i] = (i == 1);
         add_char(11, exp_d[i], drop_f[i]);
      end
      plan_stops(7, 1'b1);
      repeat (33) add_bit(1'b1);
      play();
      check_stream(11, 7, 1, -1, "R5", "R6");

      // R7: break of 30 spaces at M=8 (threshold 19), then recovery
      len_sel = 2'd0; ext_rate = 1'b0;
      do_reset();
      repeat (30) add_bit(1'b0);
      repeat (20) add_bit(1'b1);
      d = int'($urandom) & 8'h3F;
      exp_d[0] = d; exp_st[0] = -1;
      add_char(8, d, 1'b0);
      repeat (24) add_bit(1'b1);
      play();
      chk(lg[230] == 1'b1, "R5 stop inserted before break", lg[230], 1);
      ones = 0;
      for (int k = 290; k < 482; k++) ones += int'(lg[k]);
      chk(ones == 0, "R7 break held at space", ones, 0);
      chk(lg[482] == 1'b1, "R7 mark after break", lg[482], 1);
      check_stream(8, 1, 483, TPB * 57 + 2, "R7", "R7");

      // R8: high-speed-timing path, one clock after each strobe
      hs_mode = 1'b1;
      do_reset();
      for (int b = 0; b < 40; b++) add_bit(1'($urandom % 2));
      play();
      for (int b = 0; b < 40; b++) begin
         chk(lg[TPB * b + 1] == txb[b], "R8 high-speed follow", lg[TPB * b + 1], txb[b]);
      end

      // R9: bypass overrides everything, same cycle
      sync_bypass = 1'b1;
      for (int i = 0; i < 8; i++) begin
         @(negedge clk);
         rx_data = 1'($urandom % 2);
         bit_stb = 1'b0;
         #1;
         chk(async_out == rx_data, "R9 bypass", async_out, rx_data);
      end
      sync_bypass = 1'b0;
      hs_mode = 1'b0;

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule